// File: doc/BRIEF.md
# Single-Wire Bus Receive Path

This block turns the digitized outputs of the two bus comparators of a single-wire bus transceiver into the receive-data level for the protocol controller. The first comparator trips at the normal dominant threshold. The second trips only at the raised wake-up voltage. In the active modes the normal comparator bit is synchronized and passed through a minimum-pulse filter. It then drives the receive output, where low means a dominant bus. For a short window after the local transmitter lets go of the bus, the output is held recessive so that line ringing cannot echo back as data.

While the transceiver sleeps, ordinary bus traffic is kept off the receive output. The raised-voltage comparator feeds a duration filter. Only a raised level that lasts the whole wake window counts as a wake-up. A valid wake-up gives the mode controller a one-cycle event and pulls the receive output low, where it serves as an interrupt until the controller acts on it. All durations are counted in periods of a free-running microsecond strobe, so the clock frequency does not enter the parameters.

The receive output is a plain registered level with no handshake. It tracks the bus continuously and has no back-pressure: the controller samples it whenever it likes.

Top module: `swrx_receive`

## Requirements
- R1: In the active modes (mode code 2 fast download, 3 raised-voltage, 4 normal), `rxd` is 0 while the filtered normal comparator (`bus_dom`, 1 = dominant) reads dominant and 1 while it reads recessive.
- R2: A change of the normal comparator level reaches `rxd` only after the new level has been held across `GLITCH_TICKS` consecutive ticks. A pulse in either direction that spans fewer ticks is not propagated.
- R3: In an active mode, a 0-to-1 transition of `txd` forces `rxd` to 1 for a window of more than `BLANK_TICKS`-1 and at most `BLANK_TICKS` tick periods, whatever the bus level. After the window `rxd` follows the filtered bus again.
- R4: In sleep (mode code 0) and standby (mode code 1), bus data never reaches `rxd`. There `rxd` is 1 unless a wake interrupt is pending.
- R5: In sleep, a raised-voltage level (`bus_hv` = 1) is a valid wake-up only after it persists for `WAKE_TICKS` ticks. Shorter pulses are ignored. A valid wake-up produces exactly one single-cycle `wake_evt` pulse, however long the level stays up.
- R6: After a valid wake-up, `rxd` is 0 as an interrupt, and it stays 0 through standby. The interrupt clears when the mode goes from standby back to sleep, or when any active mode is entered.
- R7: Wake-up detection runs only in sleep. A raised-voltage level in standby or in an active mode raises no `wake_evt`.
- R8: During and right after reset, `rxd` is 1 and `wake_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe once per microsecond |
| mode | input | 3 | Current mode from the mode controller (0 sleep, 1 standby, 2 fast, 3 raised-voltage, 4 normal) |
| txd | input | 1 | Transmit data from the controller, 0 = drive dominant |
| bus_dom | input | 1 | Asynchronous normal-threshold comparator bit, 1 = dominant |
| bus_hv | input | 1 | Asynchronous raised-voltage comparator bit, 1 = above wake threshold |
| rxd | output | 1 | Receive data / wake interrupt, 0 = dominant or interrupt |
| wake_evt | output | 1 | Single-cycle pulse on a validated wake-up |

## Verification
Two functions can meet in the same cycle. The blanking window can still be open when the glitch filter accepts a new dominant level. The bench provokes this by raising `txd` on the very cycle the bus comparator goes dominant. It then judges that `rxd` stays recessive throughout the window and drops to dominant only once the window has closed. Filter acceptance, which comes earlier, must not leak through. A second overlap, a long raised-voltage level held across the moment the interrupt appears, is judged by counting `wake_evt` pulses: the count must be exactly one.

// File: rtl/swrx_pkg.sv
package swrx_pkg;

  typedef enum logic [2:0] {
    MODE_SLEEP    = 3'd0,
    MODE_STANDBY  = 3'd1,
    MODE_FAST     = 3'd2,
    MODE_WAKEVOLT = 3'd3,
    MODE_NORMAL   = 3'd4
  } mode_e;

  // Comparator pair as seen after synchronization.
  typedef struct packed {
    logic hv;
    logic dom;
  } cmp_t;

  function automatic logic mode_active(input logic [2:0] m);
    logic a;
    case (m)
      MODE_FAST, MODE_WAKEVOLT, MODE_NORMAL: a = 1'b1;
      default:                               a = 1'b0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/swrx_sync.sv
module swrx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/swrx_glitch.sv
// Symmetric minimum-pulse filter: the output takes a new level only when
// the input has differed from it on LEN consecutive ticks.
module swrx_glitch #(
  parameter int unsigned LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt;
  logic          lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (din == lvl) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == CW'(LEN - 1)) begin
        lvl <= din;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dout = lvl;

endmodule

// File: rtl/swrx_blank.sv
// Blanking window opened by a rising transmit edge and closed after LEN ticks.
module swrx_blank #(
  parameter int unsigned LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txd,
  input  logic arm_en,
  output logic blank
);

  localparam int unsigned CW = $clog2(LEN + 1);

  logic          txd_q;
  logic          rise;
  logic [CW-1:0] left;

  assign rise = txd && !txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1;
      left  <= '0;
    end else begin
      txd_q <= txd;
      if (rise && arm_en)         left <= CW'(LEN);
      else if (tick && left != 0) left <= left - 1'b1;
    end
  end

  assign blank = (left != '0);

endmodule

// File: rtl/swrx_wake.sv
// Duration filter for raised-voltage wake-up plus the interrupt latch.
module swrx_wake #(
  parameter int unsigned LEN = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hv,
  input  logic sleeping,
  input  logic clr_irq,
  output logic evt,
  output logic irq
);

  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt;
  logic          evt_q;
  logic          irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      evt_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (clr_irq) irq_q <= 1'b0;
      if (!hv || !sleeping || irq_q) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(LEN - 1)) begin
          cnt   <= '0;
          evt_q <= 1'b1;
          irq_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign evt = evt_q;
  assign irq = irq_q;

endmodule

// File: rtl/swrx_receive.sv
module swrx_receive
  import swrx_pkg::*;
#(
  parameter int unsigned GLITCH_TICKS = 1,
  parameter int unsigned BLANK_TICKS  = 3,
  parameter int unsigned WAKE_TICKS   = 40,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] mode,
  input  logic       txd,
  input  logic       bus_dom,
  input  logic       bus_hv,
  output logic       rxd,
  output logic       wake_evt
);

  cmp_t  raw, cmp;
  logic  flt_dom;
  logic  blank;
  logic  act;
  logic  sleeping;
  logic  clr_irq;
  logic  irq;
  logic  evt;
  logic  rxd_q;
  logic [2:0] mode_q;

  assign raw.dom = bus_dom;
  assign raw.hv  = bus_hv;

  swrx_sync #(.W($bits(cmp_t)), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(cmp)
  );

  swrx_glitch #(.LEN(GLITCH_TICKS)) u_glitch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .din(cmp.dom), .dout(flt_dom)
  );

  assign act      = mode_active(mode);
  assign sleeping = (mode == MODE_SLEEP);

  swrx_blank #(.LEN(BLANK_TICKS)) u_blank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .arm_en(act), .blank(blank)
  );

  // Interrupt is dropped on entry to an active mode or on standby -> sleep.
  assign clr_irq = act || (mode_q == MODE_STANDBY && sleeping);

  swrx_wake #(.LEN(WAKE_TICKS)) u_wake (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hv(cmp.hv), .sleeping(sleeping),
    .clr_irq(clr_irq), .evt(evt), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      rxd_q  <= 1'b1;
    end else begin
      mode_q <= mode;
      if (act) rxd_q <= blank | ~flt_dom;
      else     rxd_q <= ~irq;
    end
  end

  assign rxd      = rxd_q;
  assign wake_evt = evt;

endmodule

// File: rtl/swrx_receive_chk.sv
module swrx_receive_chk
  import swrx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       txd,
  input logic       rxd,
  input logic       wake_evt
);

  logic act;
  assign act = mode_active(mode);

  // R3: a rising transmit edge in an active mode blanks the receive output.
  assert_blank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && txd && !$past(txd) && act) ##1 act |=> rxd);

  // R5: the wake event lasts a single cycle.
  assert_evt_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !wake_evt);

  // R6: a wake event outside the active modes pulls the receive output low.
  assert_wake_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !act) |=> !rxd);

  // R7: wake events come only out of sleep.
  assert_evt_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> ($past(mode) == MODE_SLEEP));

endmodule

bind swrx_receive swrx_receive_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .txd(txd), .rxd(rxd), .wake_evt(wake_evt)
);

// File: tb/test_swrx_receive.sv
module test_swrx_receive;

  localparam int TICK_PER = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] mode = 3'd4;
  logic       txd = 1'b1;
  logic       bus_dom = 1'b0;
  logic       bus_hv = 1'b0;
  logic       rxd;
  logic       wake_evt;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int evt_cnt = 0;
  int tcnt = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    val;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t mon_e;

  always #2 clk = ~clk;

  swrx_receive #(.GLITCH_TICKS(2), .BLANK_TICKS(3), .WAKE_TICKS(5)) i_swrx_receive (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .txd(txd),
    .bus_dom(bus_dom), .bus_hv(bus_hv), .rxd(rxd), .wake_evt(wake_evt)
  );

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tcnt <= (tcnt == TICK_PER - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TICK_PER - 1);
    if (rst_n && wake_evt) evt_cnt <= evt_cnt + 1;
  end

  // Monitor: pops expected receive levels when they fall due.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      mon_e = sbq.pop_front();
      n_tests++;
      if (rxd !== mon_e.val) begin
        n_fail++;
        $display("FAIL %s: rxd=%0b expected %0b (cycle %0d)", mon_e.tag, rxd, mon_e.val, cyc);
      end
    end
  end

  task automatic push_rx(input int dly, input bit v, input string tag);
    exp_t e;
    e.due = cyc + dly;
    e.val = v;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_evt(input int exp_n, input string tag);
    n_tests++;
    if (evt_cnt != exp_n) begin
      n_fail++;
      $display("FAIL %s: wake events=%0d expected %0d", tag, evt_cnt, exp_n);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run stalled, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    // R8: reset state
    n_tests++;
    if (rxd !== 1'b1 || wake_evt !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: rxd=%0b wake_evt=%0b expected 1 0", rxd, wake_evt);
    end
    rst_n = 1'b1;
    wait_cyc(3);
    n_tests++;
    if (rxd !== 1'b1 || wake_evt !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: rxd=%0b wake_evt=%0b expected 1 0 after release", rxd, wake_evt);
    end

    // R1: normal mode follows the bus
    bus_dom = 1'b1; push_rx(30, 1'b0, "R1 dominant");  wait_cyc(40);
    bus_dom = 1'b0; push_rx(30, 1'b1, "R1 recessive"); wait_cyc(40);

    // R2: short dominant glitch
    bus_dom = 1'b1;
    push_rx(3, 1'b1, "R2 glitch"); push_rx(12, 1'b1, "R2 glitch"); push_rx(30, 1'b1, "R2 glitch");
    wait_cyc(4); bus_dom = 1'b0; wait_cyc(40);
    // R2: short recessive gap inside a dominant level
    bus_dom = 1'b1; wait_cyc(40);
    bus_dom = 1'b0;
    push_rx(3, 1'b0, "R2 gap"); push_rx(12, 1'b0, "R2 gap"); push_rx(30, 1'b0, "R2 gap");
    wait_cyc(4); bus_dom = 1'b1; wait_cyc(40);

    // R3: own transmit released while bus stays dominant
    txd = 1'b0; wait_cyc(10);
    txd = 1'b1;
    push_rx(4, 1'b1, "R3 blank"); push_rx(12, 1'b1, "R3 blank"); push_rx(34, 1'b0, "R3 after blank");
    wait_cyc(40);
    bus_dom = 1'b0; wait_cyc(40);

    // R3 with R2: filter accepts dominant while blank is open
    txd = 1'b0; wait_cyc(5);
    txd = 1'b1; bus_dom = 1'b1;
    push_rx(12, 1'b1, "R3 overlap"); push_rx(34, 1'b0, "R3 overlap end");
    wait_cyc(40);
    bus_dom = 1'b0; wait_cyc(40);

    // R1: raised-voltage mode also passes data
    mode = 3'd3; bus_dom = 1'b1; push_rx(30, 1'b0, "R1 mode3"); wait_cyc(40);
    bus_dom = 1'b0; wait_cyc(40);

    // R4: sleep blocks normal data
    mode = 3'd0; wait_cyc(5);
    bus_dom = 1'b1; push_rx(30, 1'b1, "R4 sleep"); wait_cyc(40);
    bus_dom = 1'b0; wait_cyc(10);

    // R5: short raised-voltage pulse ignored
    bus_hv = 1'b1; bus_dom = 1'b1;
    push_rx(25, 1'b1, "R5 short");
    wait_cyc(20); bus_hv = 1'b0; bus_dom = 1'b0;
    push_rx(40, 1'b1, "R5 short after");
    wait_cyc(50);
    chk_evt(0, "R5 short");

    // R5: long raised-voltage level, one event only
    bus_hv = 1'b1; bus_dom = 1'b1;
    push_rx(60, 1'b0, "R6 interrupt");
    wait_cyc(80); bus_hv = 1'b0; bus_dom = 1'b0; wait_cyc(10);
    chk_evt(1, "R5 single event");

    // R6: held in standby, cleared on return to sleep
    mode = 3'd1;
    bus_dom = 1'b1; push_rx(20, 1'b0, "R6 standby hold"); wait_cyc(30);
    bus_dom = 1'b0; push_rx(20, 1'b0, "R6 standby hold"); wait_cyc(30);
    mode = 3'd0; push_rx(4, 1'b1, "R6 clear on sleep"); wait_cyc(10);

    // R6: second wake, cleared by entering normal mode
    bus_hv = 1'b1; bus_dom = 1'b1; wait_cyc(80);
    bus_hv = 1'b0; bus_dom = 1'b0; wait_cyc(10);
    chk_evt(2, "R5 second wake");
    push_rx(2, 1'b0, "R6 second interrupt"); wait_cyc(30);
    mode = 3'd4; push_rx(4, 1'b1, "R6 clear on active"); wait_cyc(10);
    mode = 3'd0; push_rx(4, 1'b1, "R6 stays cleared"); wait_cyc(10);

    // R7: raised level in normal mode gives data, not a wake
    mode = 3'd4;
    bus_hv = 1'b1; bus_dom = 1'b1; push_rx(40, 1'b0, "R7 normal data");
    wait_cyc(80); bus_hv = 1'b0; bus_dom = 1'b0; wait_cyc(40);
    chk_evt(2, "R7 normal");
    // R7: raised level in standby gives no wake
    mode = 3'd1; wait_cyc(5);
    bus_hv = 1'b1; bus_dom = 1'b1; push_rx(60, 1'b1, "R7 standby");
    wait_cyc(80); bus_hv = 1'b0; bus_dom = 1'b0; wait_cyc(10);
    chk_evt(2, "R7 standby");

    while (sbq.size() > 0) wait_cyc(1);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule